// File: doc/BRIEF.md
# Receive Frame Status Classifier

This block sits beside an Ethernet receive path. It watches each frame as it arrives on a byte stream, one byte per beat. Each beat carries a start marker, an end marker and a valid qualifier. While the frame streams past, the block counts its bytes. It captures the length/type field and the control opcode, and it gathers error flags raised by the stream source. On the beat that ends the frame, the block compares the frame against the Ethernet size and length rules, and it receives the CRC verdict as an input flag.

One cycle after that end beat, the block presents three results: a 10-bit status word with one fixed bit per condition, an accept or drop decision, and the number of bytes to deliver. A set of mode inputs chooses which error classes may still be delivered. Other mode inputs choose whether pause frames pass on, and whether the FCS, or the FCS together with any pad, is trimmed from the delivered length. CRC computation, buffering and descriptor handling belong to neighbouring blocks.

Top module: `rx_frame_classifier`

## Requirements
- R1: `statusValid` is high for exactly one cycle. That cycle is the one after the clock edge that takes in the beat carrying the end marker of an open frame. When `statusValid` is low, `statusWord`, `frameAccept` and `frameLen` are all zero.
- R2: Status bit 9 (overrun) is set when `inOverrun` is high on any beat of the frame. A frame with this bit set is always dropped.
- R3: Status bit 8 (pause) is set when the frame has at least 18 bytes, bytes 12..13 equal 0x8808 and bytes 14..15 equal 0x0001. This bit is not an error. A pause frame with no error bit set is accepted only when `modePassPause` is high.
- R4: Status bit 7 (bad packet) is set when `inRxErr` is high on any beat of the frame. Such a frame is always dropped.
- R5: Status bit 6 (runt) is set for frames shorter than 64 bytes, which are dropped unless `modeAcceptRunt` is high. Status bit 5 (short event) is set for frames shorter than 14 bytes, which are always dropped.
- R6: Status bit 3 (FCS error) copies `inFcsBad` on the end beat, and such a frame is dropped unless `modeAcceptFcsErr` is high. Status bit 4 (alignment) is set when `inDribble` and `inFcsBad` are both high on the end beat, and such a frame is always dropped.
- R7: Status bit 2 (too long) is set for frames longer than 1518 bytes, which are dropped unless `modeAcceptLong` is high.
- R8: Status bit 1 (out of range) is set when the frame has at least 14 bytes and bytes 12..13, taken big-endian, are between 1501 and 1535. Such a frame is always dropped.
- R9: Status bit 0 (in range) is set when the frame has at least 14 bytes, the field in bytes 12..13 is 1500 or less, and the field does not match the data length. The data length is the frame length minus 18. The frame also mismatches if it has fewer than 18 bytes. A field below 46 must meet a data length of exactly 46. Such a frame is dropped unless `modeAcceptInRange` is high.
- R10: `frameLen` follows the trimming modes, and `modeStripPadFcs` has priority over `modeStripFcs`.
  - With no trimming mode set, `frameLen` is the byte count.
  - With `modeStripFcs`, `frameLen` is the byte count minus 4.
  - With `modeStripPadFcs`, `frameLen` is 14 plus the field, if the frame is padded. A padded frame has a field below 46, at least 18 bytes and bit 0 clear. Any other frame gives the byte count minus 4.
- R11: A start marker on a valid beat always opens a new frame and discards a partly received one. Beats with `inValid` low are not counted. Valid beats outside a frame without a start marker produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Byte beat qualifier |
| inSof | input | 1 | First byte of a frame |
| inEof | input | 1 | Last byte of a frame |
| inData | input | 8 | Received byte |
| inFcsBad | input | 1 | CRC check failed (end beat) |
| inDribble | input | 1 | Frame ended off an octet boundary (end beat) |
| inOverrun | input | 1 | Receive buffer had no room (any beat) |
| inRxErr | input | 1 | Line receive error (any beat) |
| modeAcceptRunt | input | 1 | Deliver runt frames |
| modeAcceptFcsErr | input | 1 | Deliver frames with bad FCS |
| modeAcceptLong | input | 1 | Deliver oversize frames |
| modeAcceptInRange | input | 1 | Deliver frames with a length-field mismatch |
| modeStripPadFcs | input | 1 | Trim pad and FCS from the delivered length |
| modeStripFcs | input | 1 | Trim FCS from the delivered length |
| modePassPause | input | 1 | Deliver pause frames |
| statusValid | output | 1 | Result strobe |
| statusWord | output | 10 | Per-condition status bits |
| frameAccept | output | 1 | Frame is to be delivered |
| frameLen | output | LEN_W | Bytes to deliver |

## Verification
The bench builds the block with its default parameters: an 11-bit length counter, a 64-byte minimum, a 1518-byte maximum and a 14-byte short-event limit. With these values a 1519-byte frame costs only a few thousand cycles, so the oversize boundary is driven directly next to the 63/64-byte runt boundary and a sub-14-byte short event. The 46-byte minimum data length follows from the defaults, which brings both padded and mismatched length fields within reach of the trimming checks.

// File: rtl/rxcls_pkg.sv
package rxcls_pkg;

  localparam int STATUS_W = 10;

  // status bit positions
  localparam int ST_OVERRUN  = 9;
  localparam int ST_PAUSE    = 8;
  localparam int ST_BAD      = 7;
  localparam int ST_RUNT     = 6;
  localparam int ST_SHORT    = 5;
  localparam int ST_ALIGN    = 4;
  localparam int ST_FCS      = 3;
  localparam int ST_LONG     = 2;
  localparam int ST_OUTRANGE = 1;
  localparam int ST_INRANGE  = 0;

  // frame layout
  localparam int HDR_BYTES  = 14;
  localparam int FCS_BYTES  = 4;
  localparam int TYPE_POS   = 12;
  localparam int OPC_POS    = 14;
  localparam int TYPE_SPLIT = 1536;
  localparam logic [15:0] PAUSE_TYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OPC  = 16'h0001;

  typedef struct packed {
    logic beat;
    logic first;
    logic last;
  } rxStrobe_t;

endpackage

// File: rtl/rxcls_ctrl.sv
module rxcls_ctrl
  import rxcls_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inSof,
  input  logic      inEof,
  output rxStrobe_t strobe
);

  logic inFrame;
  logic beatOk;

  always_comb begin
    beatOk       = inValid & (inSof | inFrame);
    strobe.beat  = beatOk;
    strobe.first = inValid & inSof;
    strobe.last  = beatOk & inEof;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame <= 1'b0;
    end else if (strobe.last) begin
      inFrame <= 1'b0;
    end else if (strobe.first) begin
      inFrame <= 1'b1;
    end
  end

endmodule

// File: rtl/rxcls_dp.sv
module rxcls_dp
  import rxcls_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int MIN_LEN   = 64,
  parameter int MAX_LEN   = 1518,
  parameter int SHORT_LEN = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  rxStrobe_t           strobe,
  input  logic [7:0]          inData,
  input  logic                inFcsBad,
  input  logic                inDribble,
  input  logic                inOverrun,
  input  logic                inRxErr,
  input  logic                modeAcceptRunt,
  input  logic                modeAcceptFcsErr,
  input  logic                modeAcceptLong,
  input  logic                modeAcceptInRange,
  input  logic                modeStripPadFcs,
  input  logic                modeStripFcs,
  input  logic                modePassPause,
  output logic                statusValid,
  output logic [STATUS_W-1:0] statusWord,
  output logic                frameAccept,
  output logic [LEN_W-1:0]    frameLen
);

  localparam int MIN_PAYLOAD = MIN_LEN - HDR_BYTES - FCS_BYTES;
  localparam int MAX_FIELD   = MAX_LEN - HDR_BYTES - FCS_BYTES;
  localparam int TAIL_BYTES  = HDR_BYTES + FCS_BYTES;
  localparam logic [LEN_W-1:0] LEN_SAT = '1;

  logic [LEN_W-1:0] byteCnt;
  logic [15:0]      typeField;
  logic [15:0]      opField;
  logic             errSticky;
  logic             ovrSticky;

  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] curLen;
  logic [15:0]      typeNow;
  logic [15:0]      opNow;
  logic             errNow;
  logic             ovrNow;
  int               lenI;
  int               fieldI;
  int               payloadI;
  logic             hasType;
  logic [STATUS_W-1:0] stNow;
  logic             accNow;
  int               outLenI;

  // running position and field capture
  always_comb begin
    idx     = strobe.first ? '0 : byteCnt;
    curLen  = (idx == LEN_SAT) ? LEN_SAT : idx + 1'b1;
    typeNow = typeField;
    opNow   = opField;
    if (idx == LEN_W'(TYPE_POS))     typeNow[15:8] = inData;
    if (idx == LEN_W'(TYPE_POS + 1)) typeNow[7:0]  = inData;
    if (idx == LEN_W'(OPC_POS))      opNow[15:8]   = inData;
    if (idx == LEN_W'(OPC_POS + 1))  opNow[7:0]    = inData;
    errNow  = inRxErr   | (!strobe.first & errSticky);
    ovrNow  = inOverrun | (!strobe.first & ovrSticky);
  end

  // classification at the end beat
  always_comb begin
    lenI     = int'(curLen);
    fieldI   = int'(typeNow);
    payloadI = lenI - TAIL_BYTES;
    hasType  = lenI >= HDR_BYTES;
    stNow    = '0;
    stNow[ST_OVERRUN]  = ovrNow;
    stNow[ST_PAUSE]    = (lenI >= TAIL_BYTES) && (typeNow == PAUSE_TYPE) && (opNow == PAUSE_OPC);
    stNow[ST_BAD]      = errNow;
    stNow[ST_RUNT]     = lenI < MIN_LEN;
    stNow[ST_SHORT]    = lenI < SHORT_LEN;
    stNow[ST_ALIGN]    = inDribble & inFcsBad;
    stNow[ST_FCS]      = inFcsBad;
    stNow[ST_LONG]     = lenI > MAX_LEN;
    stNow[ST_OUTRANGE] = hasType && (fieldI > MAX_FIELD) && (fieldI < TYPE_SPLIT);
    stNow[ST_INRANGE]  = hasType && (fieldI <= MAX_FIELD) &&
                         ((lenI < TAIL_BYTES) ||
                          ((fieldI < MIN_PAYLOAD) ? (payloadI != MIN_PAYLOAD) : (payloadI != fieldI)));

    accNow = !(stNow[ST_OVERRUN] | stNow[ST_BAD] | stNow[ST_SHORT] |
               stNow[ST_ALIGN] | stNow[ST_OUTRANGE]) &&
             (!stNow[ST_RUNT]    || modeAcceptRunt) &&
             (!stNow[ST_FCS]     || modeAcceptFcsErr) &&
             (!stNow[ST_LONG]    || modeAcceptLong) &&
             (!stNow[ST_INRANGE] || modeAcceptInRange) &&
             (!stNow[ST_PAUSE]   || modePassPause);

    if (modeStripPadFcs && (lenI >= TAIL_BYTES) && (fieldI < MIN_PAYLOAD) && !stNow[ST_INRANGE]) begin
      outLenI = HDR_BYTES + fieldI;
    end else if (modeStripPadFcs || modeStripFcs) begin
      outLenI = (lenI >= FCS_BYTES) ? lenI - FCS_BYTES : 0;
    end else begin
      outLenI = lenI;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt     <= '0;
      typeField   <= '0;
      opField     <= '0;
      errSticky   <= 1'b0;
      ovrSticky   <= 1'b0;
      statusValid <= 1'b0;
      statusWord  <= '0;
      frameAccept <= 1'b0;
      frameLen    <= '0;
    end else begin
      if (strobe.beat) begin
        byteCnt   <= curLen;
        typeField <= typeNow;
        opField   <= opNow;
        errSticky <= errNow;
        ovrSticky <= ovrNow;
      end
      statusValid <= strobe.last;
      statusWord  <= strobe.last ? stNow : '0;
      frameAccept <= strobe.last & accNow;
      frameLen    <= strobe.last ? LEN_W'(outLenI) : '0;
    end
  end

endmodule

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier
  import rxcls_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int MIN_LEN   = 64,
  parameter int MAX_LEN   = 1518,
  parameter int SHORT_LEN = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEof,
  input  logic [7:0]       inData,
  input  logic             inFcsBad,
  input  logic             inDribble,
  input  logic             inOverrun,
  input  logic             inRxErr,
  input  logic             modeAcceptRunt,
  input  logic             modeAcceptFcsErr,
  input  logic             modeAcceptLong,
  input  logic             modeAcceptInRange,
  input  logic             modeStripPadFcs,
  input  logic             modeStripFcs,
  input  logic             modePassPause,
  output logic             statusValid,
  output logic [9:0]       statusWord,
  output logic             frameAccept,
  output logic [LEN_W-1:0] frameLen
);

  rxStrobe_t strobe;

  rxcls_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inSof   (inSof),
    .inEof   (inEof),
    .strobe  (strobe)
  );

  rxcls_dp #(
    .LEN_W     (LEN_W),
    .MIN_LEN   (MIN_LEN),
    .MAX_LEN   (MAX_LEN),
    .SHORT_LEN (SHORT_LEN)
  ) u_dp (
    .clk               (clk),
    .rstN              (rstN),
    .strobe            (strobe),
    .inData            (inData),
    .inFcsBad          (inFcsBad),
    .inDribble         (inDribble),
    .inOverrun         (inOverrun),
    .inRxErr           (inRxErr),
    .modeAcceptRunt    (modeAcceptRunt),
    .modeAcceptFcsErr  (modeAcceptFcsErr),
    .modeAcceptLong    (modeAcceptLong),
    .modeAcceptInRange (modeAcceptInRange),
    .modeStripPadFcs   (modeStripPadFcs),
    .modeStripFcs      (modeStripFcs),
    .modePassPause     (modePassPause),
    .statusValid       (statusValid),
    .statusWord        (statusWord),
    .frameAccept       (frameAccept),
    .frameLen          (frameLen)
  );

endmodule

// File: rtl/rxcls_chk.sv
module rxcls_chk #(
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             lastStrobe,
  input logic             statusValid,
  input logic [9:0]       statusWord,
  input logic             frameAccept,
  input logic [LEN_W-1:0] frameLen,
  input logic             modePassPause
);

  // R1: result follows the end beat by one cycle
  a_r1_result_after_end: assert property (@(posedge clk) disable iff (!rstN)
    lastStrobe |=> statusValid);

  // R1: no result without an end beat
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !lastStrobe |=> !statusValid);

  // R1: quiet outputs outside the result cycle
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !statusValid |-> (statusWord == '0 && !frameAccept && frameLen == '0));

  // R2: overrun always drops
  a_r2_overrun_drops: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && statusWord[9]) |-> !frameAccept);

  // R3: pause consumed unless passed on
  a_r3_pause_consumed: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && statusWord[8] && !$past(modePassPause)) |-> !frameAccept);

  // R4: bad packet always drops
  a_r4_bad_drops: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && statusWord[7]) |-> !frameAccept);

  // R5: a short event is also a runt
  a_r5_short_is_runt: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && statusWord[5]) |-> statusWord[6]);

  // R6: alignment error comes with an FCS error
  a_r6_align_has_fcs: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && statusWord[4]) |-> (statusWord[3] && !frameAccept));

  // R7: oversize and runt exclude each other
  a_r7_long_not_runt: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |-> !(statusWord[2] && statusWord[6]));

  // R8: out-of-range always drops
  a_r8_outrange_drops: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && statusWord[1]) |-> !frameAccept);

endmodule

bind rx_frame_classifier rxcls_chk #(.LEN_W(LEN_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .lastStrobe    (strobe.last),
  .statusValid   (statusValid),
  .statusWord    (statusWord),
  .frameAccept   (frameAccept),
  .frameLen      (frameLen),
  .modePassPause (modePassPause)
);

// File: tb/rx_frame_classifier_tb.sv
module rx_frame_classifier_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 11;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 0, inSof = 0, inEof = 0;
  logic [7:0] inData = '0;
  logic inFcsBad = 0, inDribble = 0, inOverrun = 0, inRxErr = 0;
  logic mRunt = 0, mFcs = 0, mLong = 0, mInR = 0, mPad = 0, mStrip = 0, mPause = 0;
  logic statusValid;
  logic [9:0] statusWord;
  logic frameAccept;
  logic [LEN_W-1:0] frameLen;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [21:0] expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_classifier u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inData(inData), .inFcsBad(inFcsBad), .inDribble(inDribble),
    .inOverrun(inOverrun), .inRxErr(inRxErr),
    .modeAcceptRunt(mRunt), .modeAcceptFcsErr(mFcs), .modeAcceptLong(mLong),
    .modeAcceptInRange(mInR), .modeStripPadFcs(mPad), .modeStripFcs(mStrip),
    .modePassPause(mPause),
    .statusValid(statusValid), .statusWord(statusWord),
    .frameAccept(frameAccept), .frameLen(frameLen)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // expected result from the requirements: {status[9:0], accept, len[10:0]}
  function automatic logic [21:0] model(int len, int typ, int op, bit fcs, bit drib, bit ovr, bit err);
    logic [9:0] st;
    bit acc, hasT;
    int outL;
    hasT = len >= 14;
    st = '0;
    st[9] = ovr;
    st[8] = (len >= 18) && typ == 16'h8808 && op == 1;
    st[7] = err;
    st[6] = len < 64;
    st[5] = len < 14;
    st[4] = drib && fcs;
    st[3] = fcs;
    st[2] = len > 1518;
    st[1] = hasT && typ > 1500 && typ < 1536;
    st[0] = hasT && typ <= 1500 && ((len < 18) || ((typ < 46) ? (len - 18 != 46) : (len - 18 != typ)));
    acc = !(st[9] || st[7] || st[5] || st[4] || st[1]) &&
          (!st[6] || mRunt) && (!st[3] || mFcs) && (!st[2] || mLong) &&
          (!st[0] || mInR) && (!st[8] || mPause);
    if (mPad && len >= 18 && typ < 46 && !st[0]) outL = 14 + typ;
    else if (mPad || mStrip) outL = (len >= 4) ? len - 4 : 0;
    else outL = len;
    return {st, acc, 11'(outL)};
  endfunction

  task automatic setMode(input logic [6:0] m);
    {mRunt, mFcs, mLong, mInR, mPad, mStrip, mPause} = m;
  endtask

  task automatic sendFrame(input string tag, input int len, input int typ, input int op,
                           input bit fcs, input bit drib, input int ovrAt, input int errAt,
                           input int gapEvery);
    expQ.push_back(model(len, typ, op, fcs, drib, ovrAt >= 0, errAt >= 0));
    tagQ.push_back(tag);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid   = 1;
      inSof     = (i == 0);
      inEof     = (i == len - 1);
      inData    = (i == 12) ? 8'(typ >> 8) : (i == 13) ? 8'(typ) :
                  (i == 14) ? 8'(op >> 8)  : (i == 15) ? 8'(op)  : 8'(i);
      inFcsBad  = (i == len - 1) && fcs;
      inDribble = (i == len - 1) && drib;
      inOverrun = (i == ovrAt);
      inRxErr   = (i == errAt);
      if (gapEvery > 0 && (i % gapEvery) == gapEvery - 1 && i != len - 1) begin
        @(negedge clk);
        inValid = 0; inSof = 0; inEof = 0; inOverrun = 0; inRxErr = 0;
      end
    end
    @(negedge clk);
    inValid = 0; inSof = 0; inEof = 0; inFcsBad = 0; inDribble = 0; inOverrun = 0; inRxErr = 0;
    repeat (2) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && statusValid) begin
      if (expQ.size() == 0) begin
        check(0, "R1/R11 unexpected result", int'(statusWord), 0);
      end else begin
        logic [21:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(statusWord == e[21:12], {t, " status"}, int'(statusWord), int'(e[21:12]));
        check(frameAccept == e[11], {t, " accept"}, int'(frameAccept), int'(e[11]));
        check(frameLen == e[10:0], {t, " length"}, int'(frameLen), int'(e[10:0]));
      end
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!statusValid && statusWord == 0 && !frameAccept && frameLen == 0,
          "R1 reset state", int'(statusWord), 0);

    setMode(7'b0000000);
    sendFrame("R1 good 64", 64, 16'h0800, 0, 0, 0, -1, -1, 0);
    sendFrame("R11 good with gaps", 80, 16'h0800, 0, 0, 0, -1, -1, 7);
    setMode(7'b0000010);
    sendFrame("R10 strip fcs", 64, 16'h0800, 0, 0, 0, -1, -1, 0);

    setMode(7'b0000000);
    sendFrame("R5 runt dropped", 63, 16'h0800, 0, 0, 0, -1, -1, 0);
    setMode(7'b1000000);
    sendFrame("R5 runt accepted", 40, 16'h0800, 0, 0, 0, -1, -1, 0);
    sendFrame("R5 short event", 10, 0, 0, 0, 0, -1, -1, 0);

    setMode(7'b0000000);
    sendFrame("R6 fcs dropped", 100, 16'h0800, 0, 1, 0, -1, -1, 0);
    setMode(7'b0100000);
    sendFrame("R6 fcs accepted", 100, 16'h0800, 0, 1, 0, -1, -1, 0);
    sendFrame("R6 alignment", 100, 16'h0800, 0, 1, 1, -1, -1, 0);
    sendFrame("R6 dribble only", 100, 16'h0800, 0, 0, 1, -1, -1, 0);

    setMode(7'b0000000);
    sendFrame("R7 long dropped", 1519, 16'h0800, 0, 0, 0, -1, -1, 0);
    sendFrame("R7 max size", 1518, 16'h0800, 0, 0, 0, -1, -1, 0);
    setMode(7'b0010000);
    sendFrame("R7 long accepted", 1519, 16'h0800, 0, 0, 0, -1, -1, 0);

    setMode(7'b0000000);
    sendFrame("R8 out of range", 100, 1504, 0, 0, 0, -1, -1, 0);
    sendFrame("R9 length ok", 118, 100, 0, 0, 0, -1, -1, 0);
    sendFrame("R9 in range dropped", 120, 100, 0, 0, 0, -1, -1, 0);
    setMode(7'b0001000);
    sendFrame("R9 in range accepted", 120, 100, 0, 0, 0, -1, -1, 0);
    setMode(7'b0000100);
    sendFrame("R10 strip pad", 64, 20, 0, 0, 0, -1, -1, 0);
    sendFrame("R10 strip pad no pad", 118, 100, 0, 0, 0, -1, -1, 0);
    setMode(7'b0000110);
    sendFrame("R10 pad priority", 64, 30, 0, 0, 0, -1, -1, 0);

    setMode(7'b0000000);
    sendFrame("R3 pause consumed", 64, 16'h8808, 1, 0, 0, -1, -1, 0);
    setMode(7'b0000001);
    sendFrame("R3 pause passed", 64, 16'h8808, 1, 0, 0, -1, -1, 0);
    sendFrame("R3 other opcode", 64, 16'h8808, 2, 0, 0, -1, -1, 0);

    setMode(7'b1111111);
    sendFrame("R2 overrun", 70, 16'h0800, 0, 0, 0, 30, -1, 0);
    sendFrame("R4 bad packet", 70, 16'h0800, 0, 0, 0, -1, 5, 0);

    // R11: stray beat outside a frame yields nothing
    @(negedge clk);
    inValid = 1; inEof = 1; inData = 8'h55;
    @(negedge clk);
    inValid = 0; inEof = 0;
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R11 stray beat ignored", expQ.size(), 0);

    // R11: start marker restarts a partial frame
    setMode(7'b0000000);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      inValid = 1; inSof = (i == 0); inEof = 0; inData = 8'(i);
      inRxErr = (i == 3);
    end
    sendFrame("R11 restart", 64, 16'h0800, 0, 0, 0, -1, -1, 0);

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R1 all results seen", expQ.size(), 0);
    summary();
  end

endmodule